// File: doc/BRIEF.md
# Dual-Mode Limit Timer/Counter

This block is a register-mapped timer with two personalities. In system mode it counts ticks from a 2 MHz tick enable. Each tick adds 0x200 to the visible count, because the count occupies bits 30..9 and bits 8..0 always read zero. When the count arrives at a programmable limit it returns to zero, latches a reached flag in bit 31 of the count word and raises a level interrupt. The interrupt stays high until software reads the limit word or rewrites it.

In user mode the same words expose a 63-bit free-running counter split across two 32-bit words. Software can stop and start it, and it never interrupts.

Access is through a plain word-indexed register bus: a write strobe, a read strobe, a word index taken from byte address bits 4:2, and write data. Read data returns one cycle after the read strobe, qualified by `rd_valid`. The bus has no back-pressure: every strobe is accepted in its own cycle, and each read produces exactly one `rd_valid` pulse one cycle later. The mode is a plain level input.

Top module: `dual_limit_timer`

## Requirements
- R1: Each accepted tick advances the count by 0x200. Bits 8..0 of every count and limit readback are zero.
- R2: A system-mode limit write keeps bits 30..9 of the data and ignores bit 31 and bits 8..0. If the kept value is zero, the limit becomes 0x7FFFFE00.
- R3: In system mode, writing word 0 loads the limit, zeroes the count and drops the interrupt. Writing word 2 loads the limit and leaves the count running.
- R4: In system mode, when a tick would bring the count to the limit or beyond it, the count becomes zero, word 1 bit 31 sets and the interrupt asserts.
- R5: Reading word 0 in system mode returns the limit with bit 31 clear, and clears both the reached flag and the interrupt. Until then the interrupt stays asserted. A wrap in the same cycle as the read wins over the clear.
- R6: Read data appears one cycle after the read strobe, with `rd_valid` high. A count read issued in the same cycle as a tick returns the value from before that tick.
- R7: In user mode, word 1 reads counter bits 31..9 (with bits 8..0 zero and no reached flag) and word 0 reads counter bits 62..32 (with bit 31 zero). Writing word 0 sets limit bits 62..32 from data bits 30..0. Writing word 1 sets limit bits 31..9 from data bits 31..9. Either write zeroes the count. A combined limit of zero becomes all ones.
- R8: Entering user mode drops the interrupt, sets the limit to all ones and zeroes the count. The interrupt never asserts while in user mode.
- R9: Word 3 reads the stopped flag in bit 0. In user mode, writing word 3 with bit 0 = 1 halts counting and bit 0 = 0 resumes it. In system mode, word 3 writes are ignored and counting never halts.
- R10: Words 2 and 4..7 read zero. Writes to words 4..7 have no effect. In system mode, writes to words 1 and 3 have no effect.
- R11: After reset the limit reads 0x7FFFFE00, the count and reached flag are zero, the interrupt is low and the stopped flag reads 1.
- R12: Leaving user mode restores the limit to 0x7FFFFE00 and zeroes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 500 ns count step |
| user_mode | input | 1 | 1 selects the split wide counter, 0 the limit timer |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_word | input | 3 | Word index (byte address bits 4:2) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response, one cycle after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
A wrong limit value becomes visible the very next time word 0 is read. It also moves the cycle on which `irq` rises by as many ticks as the error. A count that skips or repeats a tick shows up as a word 1 value that is off by a multiple of 0x200 at the next read. A reached flag or interrupt that is not cleared on time shows as bit 31 or `irq` staying high on the cycle after the limit read. A mode-entry path that fails to reset state shows at the first user-mode read, or at the first wrap that raises `irq` in user mode.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int TMR_WORD_W = 32;
  localparam int TMR_FRAC_W = 9;
  localparam int TMR_CNT_W  = 54;
  localparam int TMR_SEL_W  = 3;

  typedef enum logic [TMR_SEL_W-1:0] {
    WD_LIMIT = 3'd0,
    WD_COUNT = 3'd1,
    WD_LIMNR = 3'd2,
    WD_CTRL  = 3'd3
  } word_e;
endpackage

// File: rtl/timer_count.sv
module timer_count #(
  parameter int CW = 54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt_q,
  output logic          wrap
);
  logic [CW:0] nxt;
  logic        hit;

  assign nxt  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign hit  = nxt >= {1'b0, limit};
  assign wrap = en & ~clear & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear)      cnt_q <= '0;
    else if (en && hit)  cnt_q <= '0;
    else if (en)         cnt_q <= nxt[CW-1:0];
  end

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 9,
  parameter int CW     = 54,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  reg_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CW-1:0]     cnt,
  input  logic              wrap,
  output logic              cnt_clear,
  output logic              cnt_en,
  output logic [CW-1:0]     limit_q,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq
);
  localparam int SYS_W = WORD_W - 1 - FRAC_W;
  localparam int LO_W  = WORD_W - FRAC_W;
  localparam int HI_W  = CW - LO_W;
  localparam logic [CW-1:0] SYS_MAX = CW'({SYS_W{1'b1}});

  logic              user_q, stopped_q, reached_q, irq_q;
  logic              entry, leave;
  logic [CW-1:0]     limit_d;
  logic              stopped_d, reached_d, irq_d;
  logic [SYS_W-1:0]  sys_raw, sys_lim;
  logic [WORD_W-1:0] rd_mux;

  assign entry   = user_mode & ~user_q;
  assign leave   = ~user_mode & user_q;
  assign sys_raw = wr_data[WORD_W-2:FRAC_W];
  assign sys_lim = (sys_raw == '0) ? {SYS_W{1'b1}} : sys_raw;

  assign cnt_clear = entry | leave
                   | (wr_en && reg_word == WD_LIMIT)
                   | (user_q && wr_en && reg_word == WD_COUNT);
  assign cnt_en = tick_en & (~user_q | ~stopped_q);

  always_comb begin
    limit_d   = limit_q;
    stopped_d = stopped_q;
    reached_d = reached_q;
    irq_d     = irq_q;
    if (entry) begin
      limit_d   = '1;
      irq_d     = 1'b0;
      reached_d = 1'b0;
    end else if (leave) begin
      limit_d   = SYS_MAX;
      irq_d     = 1'b0;
      reached_d = 1'b0;
    end else if (user_q) begin
      if (wr_en && reg_word == WD_LIMIT) begin
        limit_d[CW-1:LO_W] = wr_data[HI_W-1:0];
        irq_d = 1'b0;
      end
      if (wr_en && reg_word == WD_COUNT) begin
        limit_d[LO_W-1:0] = wr_data[WORD_W-1:FRAC_W];
        irq_d = 1'b0;
      end
      if (limit_d == '0) limit_d = '1;
      if (wr_en && reg_word == WD_CTRL) stopped_d = wr_data[0];
    end else begin
      if (wr_en && (reg_word == WD_LIMIT || reg_word == WD_LIMNR))
        limit_d = CW'(sys_lim);
      if (wr_en && reg_word == WD_LIMIT) irq_d = 1'b0;
      if (rd_en && reg_word == WD_LIMIT) begin
        reached_d = 1'b0;
        irq_d     = 1'b0;
      end
      if (wrap) begin
        reached_d = 1'b1;
        irq_d     = 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_word)
      WD_LIMIT: rd_mux = user_q ? WORD_W'(cnt[CW-1:LO_W])
                                : WORD_W'({limit_q[SYS_W-1:0], {FRAC_W{1'b0}}});
      WD_COUNT: rd_mux = user_q ? {cnt[LO_W-1:0], {FRAC_W{1'b0}}}
                                : {reached_q, cnt[SYS_W-1:0], {FRAC_W{1'b0}}};
      WD_CTRL:  rd_mux = WORD_W'(stopped_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_q    <= 1'b0;
      limit_q   <= SYS_MAX;
      stopped_q <= 1'b1;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      user_q    <= user_mode;
      limit_q   <= limit_d;
      stopped_q <= stopped_d;
      reached_q <= reached_d;
      irq_q     <= irq_d;
      rd_valid  <= rd_en;
      rd_data   <= rd_en ? rd_mux : '0;
    end
  end

  assign irq = irq_q;

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !user_q) |=> (reached_q && irq_q));

  // R8
  user_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_q |-> !irq_q);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && !user_mode && rd_en && reg_word == WD_LIMIT && !wrap) |=> !irq_q);

  // R2
  limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_q != '0);

  // R6
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import timer_pkg::*;
#(
  parameter int WORD_W = TMR_WORD_W,
  parameter int FRAC_W = TMR_FRAC_W,
  parameter int CW     = TMR_CNT_W,
  parameter int SEL_W  = TMR_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  reg_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              irq
);
  logic          cnt_clear, cnt_en, wrap;
  logic [CW-1:0] cnt, limit;

  timer_regs #(
    .WORD_W(WORD_W), .FRAC_W(FRAC_W), .CW(CW), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .reg_word(reg_word), .wr_data(wr_data),
    .cnt(cnt), .wrap(wrap), .cnt_clear(cnt_clear), .cnt_en(cnt_en),
    .limit_q(limit), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  timer_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .en(cnt_en),
    .limit(limit), .cnt_q(cnt), .wrap(wrap)
  );
endmodule

// File: tb/sim_dual_limit_timer.sv
`timescale 1ns/1ps
module sim_dual_limit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, user_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  reg_word = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid, irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dual_limit_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .reg_word(reg_word), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
  );

  // monitor: pops one expected word per read response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected read response %h, expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: read got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] w, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; reg_word = w;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_tick(input logic [2:0] w, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; tick_en = 1'b1; reg_word = w;
    @(negedge clk);
    rd_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_word = w; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); user_mode = m;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk_irq(1'b0, "R11");
    rd(3'd0, 32'h7FFF_FE00, "R11");
    rd(3'd1, 32'h0, "R11");
    rd(3'd3, 32'h1, "R11");

    // R2 masking, R1 stepping, R4 wrap, R5 sticky and clear
    wr(3'd0, 32'h8000_0BFF);
    rd(3'd0, 32'h0000_0A00, "R2");
    ticks(3);
    rd(3'd1, 32'h0000_0600, "R1");
    chk_irq(1'b0, "R4");
    ticks(2);
    chk_irq(1'b1, "R4");
    ticks(1);
    chk_irq(1'b1, "R5");
    rd(3'd1, 32'h8000_0200, "R4");
    rd(3'd0, 32'h0000_0A00, "R5");
    chk_irq(1'b0, "R5");
    rd(3'd1, 32'h0000_0200, "R5");

    // R6 read together with a tick sees the old count
    rd_tick(3'd1, 32'h0000_0200, "R6");
    rd(3'd1, 32'h0000_0400, "R6");

    // R3 word 2 keeps the count, word 0 zeroes it and drops irq
    wr(3'd2, 32'h0000_1400);
    rd(3'd1, 32'h0000_0400, "R3");
    rd(3'd0, 32'h0000_1400, "R3");
    ticks(8);
    chk_irq(1'b1, "R3");
    wr(3'd0, 32'h0000_1400);
    chk_irq(1'b0, "R3");
    rd(3'd0, 32'h0000_1400, "R3");
    rd(3'd1, 32'h0, "R3");

    // R2 zero limit becomes maximum
    wr(3'd0, 32'h0000_01FF);
    rd(3'd0, 32'h7FFF_FE00, "R2");

    // R9 system mode ignores word 3 and keeps counting
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R9");
    ticks(2);
    rd(3'd1, 32'h0000_0400, "R9");

    // R10 ignored and unmapped words
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h0000_0400, "R10");
    rd(3'd5, 32'h0, "R10");
    wr(3'd6, 32'h1234_5600);
    rd(3'd0, 32'h7FFF_FE00, "R10");
    rd(3'd2, 32'h0, "R10");

    // R8 entering user mode drops a pending irq and zeroes the count
    wr(3'd0, 32'h0000_0400);
    ticks(2);
    chk_irq(1'b1, "R4");
    set_mode(1'b1);
    chk_irq(1'b0, "R8");
    rd(3'd1, 32'h0, "R8");
    rd(3'd0, 32'h0, "R8");
    rd(3'd3, 32'h1, "R9");
    ticks(2);
    rd(3'd1, 32'h0, "R9");
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h0, "R9");
    ticks(3);
    rd(3'd1, 32'h0000_0600, "R7");
    rd(3'd0, 32'h0, "R7");

    // R7 split limit, wrap without irq or reached bit
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0000_09FF);
    rd(3'd1, 32'h0, "R7");
    ticks(3);
    rd(3'd1, 32'h0000_0600, "R7");
    ticks(1);
    chk_irq(1'b0, "R8");
    rd(3'd1, 32'h0, "R7");
    wr(3'd1, 32'h0);
    ticks(5);
    rd(3'd1, 32'h0000_0A00, "R7");

    // R9 stop in user mode
    wr(3'd3, 32'h1);
    ticks(2);
    rd(3'd1, 32'h0000_0A00, "R9");

    // R12 leaving user mode
    set_mode(1'b0);
    rd(3'd0, 32'h7FFF_FE00, "R12");
    rd(3'd1, 32'h0, "R12");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R6: %0d responses missing, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule